// File: doc/BRIEF.md
# Programmable Chip-Select Channel

This block is one chip-select channel of a bus controller. Software programs a base register (the upper address bits plus a 3-bit block-size code), a 16-bit option register and a 2-bit pin-assignment field. On every bus cycle the channel compares the address, the transfer direction, the active byte lanes and the function code against that programming. When everything matches and the chosen strobe is active, it drives an active-low select and then a one-cycle bus termination. The termination can come after a programmed number of wait states, immediately (fast termination), or not at all when an external device terminates the cycle itself.

In CPU space (function code 7) the channel serves interrupt-acknowledge cycles. The base-address comparison is then replaced by a comparison of the interrupt level carried on address bits 3:1, and the channel can request an autovector along with its termination. The pin-assignment field decides what the physical pin carries: a discrete data bit, an alternate-function signal, or the select for an 8-bit or a 16-bit port. The port width is reported together with the termination.

All registers and outputs change on the rising clock edge. A bus cycle presented before an edge produces the select after that edge, and register writes take effect for the cycles that follow.

Top module: `cs_channel`

## Requirements
- R1: Base register bits [2:0] hold the block size: 0=2K, 1=8K, 2=16K, 3=64K, 4=128K, 5=256K, 6=512K, 7=1M. Bits [15:3] hold address bits [23:11]. Only the address bits at or above log2 of the block size are compared.
- R2: Option bits [14:13] select the byte lanes that match: 00 never matches, 01 matches a cycle with the lower lane active, 10 matches the upper lane, 11 matches either lane.
- R3: Option bits [12:11] select the direction: 01 matches reads only, 10 matches writes only, 11 matches both, 00 matches neither.
- R4: Option bit 10 picks the qualifying strobe: 0 uses the address strobe and 1 uses the data strobe. The select goes low after the first clock edge at which the chosen strobe is active and the cycle matches.
- R5: Option bits [9:6] with a value W from 0 to 13 give a one-cycle termination pulse in the (W+1)-th cycle after the first select cycle, with exactly one pulse per strobe.
- R6: Termination code 14 gives the termination pulse in the first select cycle.
- R7: Termination code 15 gives no termination pulse. The select is held for as long as the strobe stays active, whatever the mode bit is.
- R8: Option bits [5:4] select the address space: 00 matches function code 7 only, 01 matches user codes (bit 2 clear), 10 matches supervisor codes (bit 2 set, not 7), 11 matches any code except 7.
- R9: In CPU space, option bits [3:1] are compared with address bits [3:1], and a value of 0 matches any level. The base address is not compared in CPU space.
- R10: With option bit 0 set, autovector is asserted in the termination cycle of a CPU-space cycle, and only then.
- R11: Pin field 00 puts the discrete data input on the pin and 01 puts the alternate input on the pin. With either of them the select stays high and no termination is produced. Fields 10 and 11 put the select on the pin.
- R12: The termination carries a width flag: 1 for pin field 11 (16-bit port) and 0 for pin field 10 (8-bit port).
- R13: Option bit 15 set releases the select in the cycle after the termination pulse, even while the strobe is still active. With the bit clear, the select is held until the strobe drops.
- R14: After reset the select is high and termination and autovector are low. The select and termination are low/idle again one edge after the strobe is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Write strobe for the base register |
| base_wdata | input | 16 | Base register write data |
| opt_we | input | 1 | Write strobe for the option register |
| opt_wdata | input | 16 | Option register write data |
| pin_we | input | 1 | Write strobe for the pin-assignment field |
| pin_wdata | input | 2 | Pin-assignment write data |
| disc_data | input | 1 | Data bit driven on the pin in discrete mode |
| alt_in | input | 1 | Signal driven on the pin in alternate mode |
| bus_addr | input | 24 | Bus address |
| bus_rd | input | 1 | 1 for a read cycle, 0 for a write |
| lane_up | input | 1 | Upper byte lane active |
| lane_lo | input | 1 | Lower byte lane active |
| bus_fc | input | 3 | Function code (address space) |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| cs_n | output | 1 | Chip select, active low |
| term_valid | output | 1 | One-cycle bus termination |
| term_word | output | 1 | Termination indicates a 16-bit port |
| autovec | output | 1 | Autovector request with the termination |
| pin_out | output | 1 | Value on the physical pin |

## Verification
The address match is tried with addresses just inside and just outside the block under the smallest, a middle and the largest size code. This shows whether the compare mask follows the size code. Single-lane and both-lane cycles, reads and writes, and user, supervisor and CPU function codes are each sent against settings that should accept and settings that should reject them, so a swapped field or a wrong polarity stands out. Held strobes under several termination codes and both mode values measure the cycle of the termination pulse, the pulse count and the length of the select. This separates wait-state counting, fast termination, external termination and early release. Delaying the data strobe by one cycle tells the two strobe choices apart.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int unsigned CS_ADDR_W   = 24;
    localparam int unsigned GRAIN_LOG2  = 11;  // smallest block is 2K
    localparam int unsigned SIZE_CODE_W = 3;

    localparam logic [3:0] TERM_FAST = 4'd14;
    localparam logic [3:0] TERM_EXT  = 4'd15;
    localparam logic [2:0] FC_CPU    = 3'd7;

    typedef logic [5:0] shift_t;

    typedef enum logic [1:0] {
        PIN_DISCRETE = 2'b00,
        PIN_ALT      = 2'b01,
        PIN_CS8      = 2'b10,
        PIN_CS16     = 2'b11
    } pin_t;

    typedef struct packed {
        logic       rel_mode;   // 15
        logic [1:0] lanes;      // 14:13
        logic [1:0] dir;        // 12:11 (bit0 read, bit1 write)
        logic       use_ds;     // 10
        logic [3:0] term_code;  // 9:6
        logic [1:0] space;      // 5:4
        logic [2:0] ipl;        // 3:1
        logic       avec;       // 0
    } opt_t;

    // log2 of the block size for each size code
    function automatic shift_t size_shift(input logic [2:0] code);
        case (code)
            3'd0:    size_shift = 6'd11;
            3'd1:    size_shift = 6'd13;
            3'd2:    size_shift = 6'd14;
            3'd3:    size_shift = 6'd16;
            3'd4:    size_shift = 6'd17;
            3'd5:    size_shift = 6'd18;
            3'd6:    size_shift = 6'd19;
            default: size_shift = 6'd20;
        endcase
    endfunction

    function automatic logic space_ok(input logic [1:0] sel, input logic [2:0] fc);
        logic is_cpu;
        is_cpu = (fc == FC_CPU);
        case (sel)
            2'b00:   space_ok = is_cpu;
            2'b01:   space_ok = !fc[2];
            2'b10:   space_ok = fc[2] && !is_cpu;
            default: space_ok = !is_cpu;
        endcase
    endfunction

endpackage

// File: rtl/cs_regs.sv
module cs_regs
    import cs_pkg::*;
#(
    parameter int unsigned BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic              opt_we,
    input  logic [15:0]       opt_wdata,
    input  logic              pin_we,
    input  logic [1:0]        pin_wdata,
    output logic [BASE_W-1:0] base_q,
    output opt_t              opt_q,
    output pin_t              pin_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            opt_q  <= '0;
            pin_q  <= PIN_DISCRETE;
        end else begin
            if (base_we) base_q <= base_wdata;
            if (opt_we)  opt_q  <= opt_t'(opt_wdata);
            if (pin_we)  pin_q  <= pin_t'(pin_wdata);
        end
    end
endmodule

// File: rtl/cs_match.sv
module cs_match
    import cs_pkg::*;
#(
    parameter int unsigned ADDR_W = 24
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            rd,
    input  logic                            lane_up,
    input  logic                            lane_lo,
    input  logic [2:0]                      fc,
    input  logic [ADDR_W-GRAIN_LOG2+2:0]    base,
    input  opt_t                            opt,
    input  pin_t                            pin,
    output logic                            hit,
    output logic                            cpu_cycle
);
    localparam int unsigned FIELD_W = ADDR_W - GRAIN_LOG2;
    localparam int unsigned BASE_W  = FIELD_W + SIZE_CODE_W;

    shift_t             shift;
    logic [FIELD_W-1:0] keep;
    logic [FIELD_W-1:0] diff;
    logic               lane_hit, dir_hit, where_hit;
    logic               unused_addr;

    assign shift = size_shift(base[SIZE_CODE_W-1:0]);

    for (genvar g = 0; g < FIELD_W; g++) begin : g_mask
        assign keep[g] = (6'(g + GRAIN_LOG2) >= shift);
    end

    assign diff      = (addr[ADDR_W-1:GRAIN_LOG2] ^ base[BASE_W-1:SIZE_CODE_W]) & keep;
    assign cpu_cycle = (fc == FC_CPU);

    always_comb begin
        case (opt.lanes)
            2'b01:   lane_hit = lane_lo;
            2'b10:   lane_hit = lane_up;
            2'b11:   lane_hit = lane_lo | lane_up;
            default: lane_hit = 1'b0;
        endcase
        dir_hit = rd ? opt.dir[0] : opt.dir[1];
        if (cpu_cycle)
            where_hit = (opt.ipl == 3'd0) || (addr[3:1] == opt.ipl);
        else
            where_hit = (diff == '0);
    end

    assign hit = pin[1] && lane_hit && dir_hit && space_ok(opt.space, fc) && where_hit;

    assign unused_addr = ^{addr[GRAIN_LOG2-1:4], addr[0]};
endmodule

// File: rtl/cs_timing.sv
module cs_timing
    import cs_pkg::*;
#(
    parameter int unsigned CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic       strobe,
    input  logic [3:0] term_code,
    input  logic       rel_mode,
    input  logic       wide,
    input  logic       avec_req,
    output logic       cs_n,
    output logic       term_valid,
    output logic       term_word,
    output logic       autovec
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             active, done;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             term_nx;

    always_comb begin
        if (!active)            cnt_nx = '0;
        else if (cnt == CNT_MAX) cnt_nx = cnt;
        else                    cnt_nx = cnt + 1'b1;

        if (done || term_code == TERM_EXT)
            term_nx = 1'b0;
        else if (term_code == TERM_FAST)
            term_nx = !active;
        else
            term_nx = (cnt_nx == CNT_W'(term_code + 4'd1));
    end

    always_ff @(posedge clk) begin
        if (rst || !(hit && strobe)) begin
            active     <= 1'b0;
            done       <= 1'b0;
            cnt        <= '0;
            cs_n       <= 1'b1;
            term_valid <= 1'b0;
            term_word  <= 1'b0;
            autovec    <= 1'b0;
        end else begin
            active     <= 1'b1;
            cnt        <= cnt_nx;
            cs_n       <= rel_mode && done;
            term_valid <= term_nx;
            term_word  <= term_nx && wide;
            autovec    <= term_nx && avec_req;
            if (term_nx) done <= 1'b1;
        end
    end
endmodule

// File: rtl/cs_channel.sv
module cs_channel
    import cs_pkg::*;
#(
    parameter int unsigned ADDR_W = CS_ADDR_W,
    localparam int unsigned BASE_W = ADDR_W - GRAIN_LOG2 + SIZE_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic              opt_we,
    input  logic [15:0]       opt_wdata,
    input  logic              pin_we,
    input  logic [1:0]        pin_wdata,
    input  logic              disc_data,
    input  logic              alt_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              lane_up,
    input  logic              lane_lo,
    input  logic [2:0]        bus_fc,
    input  logic              as_n,
    input  logic              ds_n,
    output logic              cs_n,
    output logic              term_valid,
    output logic              term_word,
    output logic              autovec,
    output logic              pin_out
);
    logic [BASE_W-1:0] base_q;
    opt_t              opt_q;
    pin_t              pin_q;
    logic              hit, cpu_cycle, strobe_on;
    logic [3:0]        term_code_q;
    logic              pin_cs_q;

    cs_regs #(.BASE_W(BASE_W)) u_regs (
        .clk(clk), .rst(rst),
        .base_we(base_we), .base_wdata(base_wdata),
        .opt_we(opt_we), .opt_wdata(opt_wdata),
        .pin_we(pin_we), .pin_wdata(pin_wdata),
        .base_q(base_q), .opt_q(opt_q), .pin_q(pin_q)
    );

    cs_match #(.ADDR_W(ADDR_W)) u_match (
        .addr(bus_addr), .rd(bus_rd), .lane_up(lane_up), .lane_lo(lane_lo),
        .fc(bus_fc), .base(base_q), .opt(opt_q), .pin(pin_q),
        .hit(hit), .cpu_cycle(cpu_cycle)
    );

    assign strobe_on   = opt_q.use_ds ? !ds_n : !as_n;
    assign term_code_q = opt_q.term_code;
    assign pin_cs_q    = pin_q[1];

    cs_timing u_timing (
        .clk(clk), .rst(rst), .hit(hit), .strobe(strobe_on),
        .term_code(opt_q.term_code), .rel_mode(opt_q.rel_mode),
        .wide(pin_q == PIN_CS16), .avec_req(opt_q.avec && cpu_cycle),
        .cs_n(cs_n), .term_valid(term_valid), .term_word(term_word),
        .autovec(autovec)
    );

    always_comb begin
        case (pin_q)
            PIN_DISCRETE: pin_out = disc_data;
            PIN_ALT:      pin_out = alt_in;
            default:      pin_out = cs_n;
        endcase
    end
endmodule

// File: rtl/cs_channel_chk.sv
module cs_channel_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       term_valid,
    input logic       term_word,
    input logic       autovec,
    input logic       pin_cs,
    input logic [3:0] term_code,
    input logic       strobe_on
);
    assert_pin_blocks_select_R11: assert property (@(posedge clk) disable iff (rst)
        !pin_cs |=> (cs_n && !term_valid));

    assert_ext_no_term_R7: assert property (@(posedge clk) disable iff (rst)
        (term_code == 4'hF) |=> !term_valid);

    assert_strobe_release_R14: assert property (@(posedge clk) disable iff (rst)
        !strobe_on |=> (cs_n && !term_valid));

    assert_term_single_R5: assert property (@(posedge clk) disable iff (rst)
        term_valid |=> !term_valid);

    assert_term_under_select_R5: assert property (@(posedge clk) disable iff (rst)
        term_valid |-> !cs_n);

    assert_word_with_term_R12: assert property (@(posedge clk) disable iff (rst)
        term_word |-> term_valid);

    assert_avec_with_term_R10: assert property (@(posedge clk) disable iff (rst)
        autovec |-> term_valid);
endmodule

bind cs_channel cs_channel_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .term_valid(term_valid),
    .term_word(term_word), .autovec(autovec), .pin_cs(pin_cs_q),
    .term_code(term_code_q), .strobe_on(strobe_on)
);

// File: tb/test_cs_channel.sv
module test_cs_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_we = 0, opt_we = 0, pin_we = 0;
    logic [15:0] base_wdata = '0, opt_wdata = '0;
    logic [1:0]  pin_wdata = '0;
    logic        disc_data = 0, alt_in = 0;
    logic [23:0] bus_addr = '0;
    logic        bus_rd = 1, lane_up = 0, lane_lo = 0;
    logic [2:0]  bus_fc = 3'd1;
    logic        as_n = 1, ds_n = 1;
    logic        cs_n, term_valid, term_word, autovec, pin_out;

    int checks = 0, failures = 0;
    int s_first, s_sel, s_tat, s_tcnt, s_word, s_av, s_rel;

    always #4 clk = ~clk;  // 125 MHz

    cs_channel i_cs_channel (
        .clk(clk), .rst(rst),
        .base_we(base_we), .base_wdata(base_wdata),
        .opt_we(opt_we), .opt_wdata(opt_wdata),
        .pin_we(pin_we), .pin_wdata(pin_wdata),
        .disc_data(disc_data), .alt_in(alt_in),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .lane_up(lane_up), .lane_lo(lane_lo),
        .bus_fc(bus_fc), .as_n(as_n), .ds_n(ds_n),
        .cs_n(cs_n), .term_valid(term_valid), .term_word(term_word),
        .autovec(autovec), .pin_out(pin_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok || act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_opt(input int mode, input int lanes, input int dir,
                                           input int ds, input int code, input int space,
                                           input int ipl, input int av);
        mk_opt = {1'(mode), 2'(lanes), 2'(dir), 1'(ds), 4'(code), 2'(space), 3'(ipl), 1'(av)};
    endfunction

    task automatic wr(input logic [15:0] b, input logic [15:0] o, input logic [1:0] p);
        @(negedge clk);
        base_we = 1; base_wdata = b; opt_we = 1; opt_wdata = o; pin_we = 1; pin_wdata = p;
        @(negedge clk);
        base_we = 0; opt_we = 0; pin_we = 0;
    endtask

    // one bus cycle with strobes held for 'hold' samples; ds_lag delays the data strobe
    task automatic bus(input logic [23:0] a, input logic rd, input logic up, input logic lo,
                       input logic [2:0] fc, input int hold, input int ds_lag);
        s_first = -1; s_sel = 0; s_tat = -1; s_tcnt = 0; s_word = 0; s_av = 0;
        @(negedge clk);
        bus_addr = a; bus_rd = rd; lane_up = up; lane_lo = lo; bus_fc = fc;
        as_n = 0; ds_n = (ds_lag == 0) ? 1'b0 : 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(posedge clk); @(negedge clk);
            if (!cs_n) begin s_sel++; if (s_first < 0) s_first = i; end
            if (term_valid) begin
                s_tcnt++;
                if (s_tat < 0) begin s_tat = i; s_word = term_word; s_av = autovec; end
            end
            if (i + 1 == ds_lag) ds_n = 0;
        end
        as_n = 1; ds_n = 1;
        @(posedge clk); @(negedge clk);
        s_rel = (cs_n && !term_valid) ? 1 : 0;
    endtask

    task automatic t_reset;
        chk(1, "R14 reset cs_n", cs_n, 1);
        chk(1, "R14 reset term", term_valid, 0);
        chk(1, "R14 reset autovec", autovec, 0);
        chk(1, "R11 reset discrete pin", pin_out, 0);
    endtask

    task automatic t_block_size;
        logic [15:0] o;
        o = mk_opt(0, 3, 3, 0, 2, 3, 0, 0);
        wr(16'h1203, o, 2'b11);  // 64K at 0x120000
        bus(24'h12FFFE, 1, 1, 1, 3'd1, 6, 0);
        chk(1, "R1 64K inside sel", s_sel, 6);
        chk(1, "R14 release after strobe", s_rel, 1);
        bus(24'h130000, 1, 1, 1, 3'd1, 4, 0);
        chk(1, "R1 64K outside", s_sel, 0);
        wr(16'h1200, o, 2'b11);  // 2K
        bus(24'h1207FE, 1, 1, 1, 3'd1, 4, 0);
        chk(1, "R1 2K inside", s_sel, 4);
        bus(24'h120800, 1, 1, 1, 3'd1, 4, 0);
        chk(1, "R1 2K outside", s_sel, 0);
        wr(16'h1207, o, 2'b11);  // 1M
        bus(24'h1FFFFE, 1, 1, 1, 3'd1, 4, 0);
        chk(1, "R1 1M inside", s_sel, 4);
        bus(24'h200000, 1, 1, 1, 3'd1, 4, 0);
        chk(1, "R1 1M outside", s_sel, 0);
    endtask

    task automatic t_lanes;
        wr(16'h1203, mk_opt(0, 1, 3, 0, 0, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 0, 3'd1, 3, 0);
        chk(1, "R2 lower-only rejects upper", s_sel, 0);
        bus(24'h120000, 1, 0, 1, 3'd1, 3, 0);
        chk(1, "R2 lower-only accepts lower", s_sel, 3);
        wr(16'h1203, mk_opt(0, 2, 3, 0, 0, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 0, 3'd1, 3, 0);
        chk(1, "R2 upper-only accepts upper", s_sel, 3);
        wr(16'h1203, mk_opt(0, 0, 3, 0, 0, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd1, 3, 0);
        chk(1, "R2 lanes 00 disabled", s_sel, 0);
    endtask

    task automatic t_dir;
        wr(16'h1203, mk_opt(0, 3, 1, 0, 0, 3, 0, 0), 2'b11);
        bus(24'h120010, 0, 1, 1, 3'd1, 3, 0);
        chk(1, "R3 read-only rejects write", s_sel, 0);
        bus(24'h120010, 1, 1, 1, 3'd1, 3, 0);
        chk(1, "R3 read-only accepts read", s_sel, 3);
        wr(16'h1203, mk_opt(0, 3, 2, 0, 0, 3, 0, 0), 2'b11);
        bus(24'h120010, 1, 1, 1, 3'd1, 3, 0);
        chk(1, "R3 write-only rejects read", s_sel, 0);
        bus(24'h120010, 0, 1, 1, 3'd1, 3, 0);
        chk(1, "R3 write-only accepts write", s_sel, 3);
    endtask

    task automatic t_space;
        wr(16'h1203, mk_opt(0, 3, 3, 0, 0, 2, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd5, 3, 0);
        chk(1, "R8 supervisor accepts fc5", s_sel, 3);
        bus(24'h120000, 1, 1, 1, 3'd1, 3, 0);
        chk(1, "R8 supervisor rejects fc1", s_sel, 0);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 0, 1, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd5, 3, 0);
        chk(1, "R8 user rejects fc5", s_sel, 0);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 0, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd7, 3, 0);
        chk(1, "R8 user/sup rejects fc7", s_sel, 0);
    endtask

    task automatic t_irq;
        wr(16'h1203, mk_opt(0, 3, 3, 0, 14, 0, 3, 1), 2'b11);
        bus(24'hFFFFF6, 1, 1, 1, 3'd7, 3, 0);
        chk(1, "R9 level 3 match", s_first, 0);
        chk(1, "R10 autovector at term", s_av, 1);
        bus(24'hFFFFF4, 1, 1, 1, 3'd7, 3, 0);
        chk(1, "R9 level 2 rejected", s_sel, 0);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 14, 0, 0, 0), 2'b11);
        bus(24'hFFFFF4, 1, 1, 1, 3'd7, 3, 0);
        chk(1, "R9 level 0 any", s_sel, 3);
        chk(1, "R10 no autovector when bit clear", s_av, 0);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 14, 3, 0, 1), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd5, 3, 0);
        chk(1, "R10 no autovector outside cpu space", s_av + 10 * s_tcnt, 10);
    endtask

    task automatic t_waits;
        wr(16'h1203, mk_opt(0, 3, 3, 0, 0, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd1, 5, 0);
        chk(1, "R5 W=0 term cycle", s_tat, 1);
        chk(1, "R5 W=0 single pulse", s_tcnt, 1);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 13, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd1, 17, 0);
        chk(1, "R5 W=13 term cycle", s_tat, 14);
        chk(1, "R5 W=13 single pulse", s_tcnt, 1);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 14, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd1, 4, 0);
        chk(1, "R6 fast term cycle", s_tat, 0);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 15, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd1, 20, 0);
        chk(1, "R7 external no term", s_tcnt, 0);
        chk(1, "R7 external select held", s_sel, 20);
    endtask

    task automatic t_mode;
        wr(16'h1203, mk_opt(1, 3, 3, 0, 2, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd1, 8, 0);
        chk(1, "R13 pulse mode select length", s_sel, 4);
        chk(1, "R13 pulse mode term cycle", s_tat, 3);
        wr(16'h1203, mk_opt(1, 3, 3, 0, 15, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd1, 8, 0);
        chk(1, "R7 external holds in pulse mode", s_sel, 8);
    endtask

    task automatic t_strobe;
        wr(16'h1203, mk_opt(0, 3, 3, 1, 15, 3, 0, 0), 2'b11);
        bus(24'h120000, 0, 1, 1, 3'd1, 5, 1);
        chk(1, "R4 data strobe select start", s_first, 1);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 15, 3, 0, 0), 2'b11);
        bus(24'h120000, 0, 1, 1, 3'd1, 5, 1);
        chk(1, "R4 address strobe select start", s_first, 0);
    endtask

    task automatic t_pins;
        wr(16'h1203, mk_opt(0, 3, 3, 0, 1, 3, 0, 0), 2'b11);
        bus(24'h120000, 1, 1, 1, 3'd1, 4, 0);
        chk(1, "R12 16-bit width flag", s_word, 1);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 1, 3, 0, 0), 2'b10);
        bus(24'h120000, 1, 1, 1, 3'd1, 4, 0);
        chk(1, "R12 8-bit width flag", s_word + 10 * s_tcnt, 10);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 1, 3, 0, 0), 2'b01);
        alt_in = 1;
        bus(24'h120000, 1, 1, 1, 3'd1, 4, 0);
        chk(1, "R11 alternate blocks select", s_sel + s_tcnt, 0);
        chk(1, "R11 alternate pin high", pin_out, 1);
        alt_in = 0; #1;
        chk(1, "R11 alternate pin low", pin_out, 0);
        wr(16'h1203, mk_opt(0, 3, 3, 0, 1, 3, 0, 0), 2'b00);
        disc_data = 1;
        bus(24'h120000, 1, 1, 1, 3'd1, 4, 0);
        chk(1, "R11 discrete blocks select", s_sel + s_tcnt, 0);
        chk(1, "R11 discrete pin value", pin_out, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_block_size();
        t_lanes();
        t_dir();
        t_space();
        t_irq();
        t_waits();
        t_mode();
        t_strobe();
        t_pins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        checks++; failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule